// File: doc/BRIEF.md
# Product-Term Logic Block

This block is a small programmable logic fabric. A wide AND-array forms product terms from the block inputs and from the macrocells' own register states. Each of these signals is offered to the array in both true and inverted polarity. A shared pool of product terms is then handed out by an allocator. Each term either becomes one input of a macrocell's OR sum or drives a control role for that macrocell: a clock term, a set term, a reset term or an output-enable term. Each macrocell combines its sum as a plain combinational value, a D register or a toggle register, may invert the result, and drives one output bit together with an enable bit.

The whole function is fixed by one static configuration vector. It is loaded bit-serially through a two-pin shift port. Until a complete load has finished, the logic stays in reset and every output is quiet. A global set/reset line and a global output-enable line reach every macrocell. Each macrocell's configuration decides whether the global set/reset line sets or clears it, and whether its enable comes from the global line or from a product term.

Top module: `ptlb_block`

## Requirements
- R1: While `cfg_en` is high, each clock edge shifts `cfg_bit` in at the top of the configuration vector, so the first bit shifted ends at position 0. The logic counts as loaded only when `cfg_en` is low and the most recent high run of `cfg_en` lasted at least CFG_W edges. When not loaded, `mc_out` and `mc_oe` are all zero and every macrocell register clears at the next edge. While `cfg_en` is low, the configuration does not change.
- R2: Array signal k is `blk_in[k]` for k below N_IN, and the register state of macrocell j for k = N_IN+j. Literal 2k is signal k and literal 2k+1 is its inverse. Bit p*N_LIT+l of the configuration selects literal l into product term p, where N_LIT = 2*(N_IN+N_MC). The term is the AND of its selected literals.
- R3: A product term with no literal selected is logic 0.
- R4: The role field of term p starts at bit AND_W + p*ROLE_W. Its low 3 bits hold the kind: 0 idle, 1 sum, 2 clock, 3 set, 4 reset, 5 enable; codes 6 and 7 are idle. The next IDX_W bits hold the owning macrocell. A term that is idle, or whose owner is N_MC or above, affects no output.
- R5: A macrocell's sum is the OR of at most PT_PER_MC of the sum terms it owns, taken in ascending term index. Further sum terms it owns are ignored. A term has exactly one owner, so it can never feed two sums.
- R6: The 6-bit mode field of macrocell c starts at MODE_BASE + c*6. Bit 0 selects registered, bit 1 toggle, bit 2 invert, bit 3 product-term clock, bit 4 product-term enable and bit 5 the value loaded by global set/reset. A combinational cell outputs its sum XOR invert in the same cycle.
- R7: A registered D cell captures its sum at a clock edge. A toggle cell inverts its state at an edge where its sum is 1.
- R8: At a clock edge, the register update follows a fixed priority: global set/reset (loads mode bit 5), then any reset term, then any set term, then the normal data update.
- R9: A cell with mode bit 3 set takes its normal data update only at an edge where its clock term is 1 and was 0 at the previous edge.
- R10: The feedback literal of a macrocell carries its register state, not inverted by mode bit 2.
- R11: `mc_oe[c]` equals `g_oe`, or the OR of the cell's enable terms when mode bit 4 is set. When `mc_oe[c]` is 0, `mc_out[c]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration and the load count |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| blk_in | input | N_IN | Block inputs to the AND-array |
| g_sr | input | 1 | Global set/reset, applied at the clock edge |
| g_oe | input | 1 | Global output enable |
| mc_out | output | N_MC | Macrocell outputs, zero when disabled |
| mc_oe | output | N_MC | Macrocell output enables |

## Verification
Combinational cells and all output enables are checked one time step after the inputs change on the falling clock edge, because they settle within the same cycle. Registered results, including those that depend on set/reset priority, clock-term edges and feedback, are due at the first rising edge after the stimulus. The bench holds each stimulus across exactly one rising edge and samples on the following falling edge, so a toggle cell sees exactly one edge. After `cfg_en` drops at the end of a load, outputs are released in the same cycle, and the first register update happens at the next rising edge.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  localparam int KIND_W = 3;
  localparam int MODE_W = 6;

  typedef enum logic [KIND_W-1:0] {
    PT_IDLE = 3'd0,
    PT_SUM  = 3'd1,
    PT_CLK  = 3'd2,
    PT_SET  = 3'd3,
    PT_RST  = 3'd4,
    PT_OE   = 3'd5
  } pt_kind_e;

  // Mode field of one macrocell, LSB is regd.
  typedef struct packed {
    logic gset;
    logic poe;
    logic pclk;
    logic inv;
    logic tgl;
    logic regd;
  } mc_mode_t;

  // Terms delivered by the allocator to one macrocell.
  typedef struct packed {
    logic sum;
    logic clk;
    logic set;
    logic rst;
    logic oe;
  } mc_ctl_t;

endpackage

// File: rtl/ptlb_cfg_shift.sv
module ptlb_cfg_shift #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  output logic [CFG_W-1:0] cfg,
  output logic             loaded
);

  localparam int CNT_W = $clog2(CFG_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);

  logic [CNT_W-1:0] cnt;
  logic             en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      cnt  <= '0;
      en_d <= 1'b0;
    end else begin
      en_d <= cfg_en;
      if (cfg_en) begin
        cfg <= {cfg_bit, cfg[CFG_W-1:1]};
        if (!en_d)                 cnt <= CNT_W'(1);
        else if (cnt != CNT_FULL)  cnt <= cnt + 1'b1;
      end
    end
  end

  assign loaded = !cfg_en && (cnt == CNT_FULL);

endmodule

// File: rtl/ptlb_and_array.sv
module ptlb_and_array #(
  parameter int N_SIG = 8,
  parameter int N_PT  = 8
) (
  input  logic [N_SIG-1:0]          sig,
  input  logic [N_PT*2*N_SIG-1:0]   sel,
  output logic [N_PT-1:0]           pt
);

  localparam int N_LIT = 2 * N_SIG;

  logic [N_LIT-1:0] lit;

  for (genvar k = 0; k < N_SIG; k++) begin : g_lit
    assign lit[2*k]   = sig[k];
    assign lit[2*k+1] = ~sig[k];
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic [N_LIT-1:0] s;
    assign s     = sel[p*N_LIT +: N_LIT];
    // an empty term is 0, otherwise AND of the selected literals
    assign pt[p] = (|s) & (&(lit | ~s));
  end

endmodule

// File: rtl/ptlb_alloc.sv
module ptlb_alloc
  import ptlb_pkg::*;
#(
  parameter int N_PT      = 8,
  parameter int N_MC      = 4,
  parameter int PT_PER_MC = 5,
  parameter int IDX_W     = 3
) (
  input  logic [N_PT-1:0]                  pt,
  input  logic [N_PT*(KIND_W+IDX_W)-1:0]   role,
  output logic [N_MC-1:0]                  sum_o,
  output logic [N_MC-1:0]                  clk_o,
  output logic [N_MC-1:0]                  set_o,
  output logic [N_MC-1:0]                  rst_o,
  output logic [N_MC-1:0]                  oe_o
);

  localparam int ROLE_W = KIND_W + IDX_W;

  logic [KIND_W-1:0] kind [N_PT];
  logic [IDX_W-1:0]  own  [N_PT];

  for (genvar p = 0; p < N_PT; p++) begin : g_field
    assign kind[p] = role[p*ROLE_W +: KIND_W];
    assign own[p]  = role[p*ROLE_W+KIND_W +: IDX_W];
  end

  always_comb begin
    int taken;
    sum_o = '0;
    clk_o = '0;
    set_o = '0;
    rst_o = '0;
    oe_o  = '0;
    for (int c = 0; c < N_MC; c++) begin
      taken = 0;
      for (int p = 0; p < N_PT; p++) begin
        if (own[p] == IDX_W'(c)) begin
          if (kind[p] == PT_SUM) begin
            if (taken < PT_PER_MC) begin
              sum_o[c] = sum_o[c] | pt[p];
              taken    = taken + 1;
            end
          end else if (kind[p] == PT_CLK) begin
            clk_o[c] = clk_o[c] | pt[p];
          end else if (kind[p] == PT_SET) begin
            set_o[c] = set_o[c] | pt[p];
          end else if (kind[p] == PT_RST) begin
            rst_o[c] = rst_o[c] | pt[p];
          end else if (kind[p] == PT_OE) begin
            oe_o[c]  = oe_o[c] | pt[p];
          end
        end
      end
    end
  end

endmodule

// File: rtl/ptlb_macrocell.sv
module ptlb_macrocell
  import ptlb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     g_sr,
  input  logic     g_oe,
  input  mc_mode_t mode,
  input  mc_ctl_t  ctl,
  output logic     q,
  output logic     y,
  output logic     oe
);

  logic clk_d;
  logic fire;
  logic y_raw;

  assign fire = mode.pclk ? (ctl.clk & ~clk_d) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= 1'b0;
      clk_d <= 1'b0;
    end else if (!run) begin
      q     <= 1'b0;
      clk_d <= 1'b0;
    end else begin
      clk_d <= ctl.clk;
      if (g_sr)          q <= mode.gset;
      else if (ctl.rst)  q <= 1'b0;
      else if (ctl.set)  q <= 1'b1;
      else if (fire)     q <= mode.tgl ? (q ^ ctl.sum) : ctl.sum;
    end
  end

  assign y_raw = (mode.regd ? q : ctl.sum) ^ mode.inv;
  assign oe    = run & (mode.poe ? ctl.oe : g_oe);
  assign y     = oe & y_raw;

endmodule

// File: rtl/ptlb_block.sv
module ptlb_block
  import ptlb_pkg::*;
#(
  parameter int N_IN      = 36,
  parameter int N_MC      = 18,
  parameter int N_PT      = 90,
  parameter int PT_PER_MC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_bit,
  input  logic [N_IN-1:0] blk_in,
  input  logic            g_sr,
  input  logic            g_oe,
  output logic [N_MC-1:0] mc_out,
  output logic [N_MC-1:0] mc_oe
);

  localparam int N_SIG     = N_IN + N_MC;
  localparam int N_LIT     = 2 * N_SIG;
  localparam int AND_W     = N_PT * N_LIT;
  localparam int IDX_W     = $clog2(N_MC + 1);
  localparam int ROLE_W    = KIND_W + IDX_W;
  localparam int ROLE_BASE = AND_W;
  localparam int MODE_BASE = ROLE_BASE + N_PT * ROLE_W;
  localparam int CFG_W     = MODE_BASE + N_MC * MODE_W;

  logic [CFG_W-1:0] cfg;
  logic             loaded;
  logic [N_MC-1:0]  mc_q;
  logic [N_MC-1:0]  gsr_val;
  logic [N_PT-1:0]  pt;
  logic [N_MC-1:0]  a_sum, a_clk, a_set, a_rst, a_oe;

  ptlb_cfg_shift #(.CFG_W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .cfg_bit(cfg_bit),
    .cfg    (cfg),
    .loaded (loaded)
  );

  ptlb_and_array #(.N_SIG(N_SIG), .N_PT(N_PT)) u_arr (
    .sig({mc_q, blk_in}),
    .sel(cfg[AND_W-1:0]),
    .pt (pt)
  );

  ptlb_alloc #(
    .N_PT(N_PT), .N_MC(N_MC), .PT_PER_MC(PT_PER_MC), .IDX_W(IDX_W)
  ) u_alloc (
    .pt   (pt),
    .role (cfg[MODE_BASE-1:ROLE_BASE]),
    .sum_o(a_sum),
    .clk_o(a_clk),
    .set_o(a_set),
    .rst_o(a_rst),
    .oe_o (a_oe)
  );

  for (genvar c = 0; c < N_MC; c++) begin : g_mc
    mc_mode_t m;
    mc_ctl_t  ct;
    assign m  = mc_mode_t'(cfg[MODE_BASE+c*MODE_W +: MODE_W]);
    assign ct = '{sum: a_sum[c], clk: a_clk[c], set: a_set[c],
                  rst: a_rst[c], oe: a_oe[c]};
    assign gsr_val[c] = m.gset;

    ptlb_macrocell u_mc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (loaded),
      .g_sr (g_sr),
      .g_oe (g_oe),
      .mode (m),
      .ctl  (ct),
      .q    (mc_q[c]),
      .y    (mc_out[c]),
      .oe   (mc_oe[c])
    );
  end

endmodule

// File: rtl/ptlb_block_chk.sv
module ptlb_block_chk #(
  parameter int N_MC  = 18,
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             g_sr,
  input logic             loaded,
  input logic [N_MC-1:0]  mc_out,
  input logic [N_MC-1:0]  mc_oe,
  input logic [N_MC-1:0]  q,
  input logic [N_MC-1:0]  gsr_val,
  input logic [CFG_W-1:0] cfg
);

  // R1
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (mc_out == '0 && mc_oe == '0));

  // R1
  unload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |=> (q == '0));

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg));

  // R8
  gsr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && g_sr) |=> (q == $past(gsr_val)));

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_out & ~mc_oe) == '0);

endmodule

bind ptlb_block ptlb_block_chk #(.N_MC(N_MC), .CFG_W(CFG_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfg_en (cfg_en),
  .g_sr   (g_sr),
  .loaded (loaded),
  .mc_out (mc_out),
  .mc_oe  (mc_oe),
  .q      (mc_q),
  .gsr_val(gsr_val),
  .cfg    (cfg)
);

// File: tb/sim_ptlb_block.sv
module sim_ptlb_block;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 4, NM = 3, NP = 15, PPM = 5;
  localparam int SIGS  = NI + NM;
  localparam int LITS  = 2 * SIGS;
  localparam int RBASE = NP * LITS;
  localparam int IDXW  = 2;
  localparam int ROLEW = 3 + IDXW;
  localparam int MBASE = RBASE + NP * ROLEW;
  localparam int CW    = MBASE + NM * 6;
  localparam int WDOG  = 20000;
  localparam int K_IDLE = 0, K_SUM = 1, K_CLK = 2, K_SET = 3, K_RST = 4, K_OE = 5;

  // {blk_in[3:0], expected mc_out[2:0]} for configuration A, all enabled
  localparam logic [6:0] TAB [9] = '{
    7'b0000_010, 7'b0001_101, 7'b0011_100, 7'b1100_111, 7'b0100_110,
    7'b1000_110, 7'b1101_101, 7'b1111_101, 7'b0010_110
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_bit = 1'b0, g_sr = 1'b0, g_oe = 1'b1;
  logic [NI-1:0] blk_in = '0;
  logic [NM-1:0] mc_out, mc_oe;
  logic [CW-1:0] cv;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptlb_block #(.N_IN(NI), .N_MC(NM), .N_PT(NP), .PT_PER_MC(PPM)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .blk_in(blk_in), .g_sr(g_sr), .g_oe(g_oe), .mc_out(mc_out), .mc_oe(mc_oe)
  );

  task automatic check(input string tag, input logic [2:0] eo, input logic [2:0] ee);
    n_chk++;
    if (mc_out !== eo || mc_oe !== ee) begin
      n_err++;
      $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b", tag, mc_out, mc_oe, eo, ee);
    end
  endtask

  task automatic put_lit(input int p, input int s, input int inv);
    cv[p*LITS + 2*s + inv] = 1'b1;
  endtask

  task automatic put_role(input int p, input int kind, input int owner);
    cv[RBASE + p*ROLEW +: 3]      = 3'(kind);
    cv[RBASE + p*ROLEW + 3 +: IDXW] = IDXW'(owner);
  endtask

  // mode bits {gset,poe,pclk,inv,tgl,regd}
  task automatic put_mode(input int c, input logic [5:0] m);
    cv[MBASE + c*6 +: 6] = m;
  endtask

  task automatic load();
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_bit = cv[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  // drive at a falling edge, cross one rising edge, check at the next falling edge
  task automatic step(input logic [3:0] din, input logic sr, input string tag,
                      input logic [2:0] eo, input logic [2:0] ee);
    blk_in = din;
    g_sr   = sr;
    @(negedge clk);
    check(tag, eo, ee);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 reset state quiet", 3'b000, 3'b000);

    // configuration A: combinational cells
    cv = '0;
    put_lit(0, 0, 0); put_lit(0, 1, 1); put_role(0, K_SUM, 0);
    put_lit(1, 2, 0); put_lit(1, 3, 0); put_role(1, K_SUM, 0);
    put_lit(2, 0, 0); put_role(2, K_SUM, 1);
    for (int p = 3; p < 7; p++) begin
      put_lit(p, p - 3, 0); put_role(p, K_SUM, 2);
    end
    put_role(7, K_SUM, 2);                       // empty term, 5th sum of cell 2
    for (int s = 0; s < 4; s++) put_lit(8, s, 1); // 6th sum term, dropped
    put_role(8, K_SUM, 2);
    put_role(9, K_SUM, 0);                       // empty term
    put_lit(10, 0, 0); put_role(10, K_SUM, 3);   // owner out of range
    put_lit(11, 1, 0); put_role(11, K_IDLE, 1);
    put_lit(12, 1, 0); put_role(12, 6, 1);       // undefined kind
    put_mode(0, 6'b000000);
    put_mode(1, 6'b000100);
    put_mode(2, 6'b000000);
    load();

    for (int i = 0; i < 9; i++) begin
      blk_in = TAB[i][6:3];
      #1 check($sformatf("R2 R3 R4 R5 R6 table entry %0d", i), TAB[i][2:0], 3'b111);
      @(negedge clk);
    end

    blk_in = 4'b0001; g_oe = 1'b0;
    #1 check("R11 global enable low", 3'b000, 3'b000);
    g_oe = 1'b1;

    // partial load must keep the logic quiet
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      cfg_en = 1'b1; cfg_bit = 1'b1;
      @(negedge clk);
    end
    check("R1 quiet while shifting", 3'b000, 3'b000);
    cfg_en = 1'b0;
    #1 check("R1 partial load not loaded", 3'b000, 3'b000);

    // configuration B: registered cells, controls and feedback
    blk_in = '0;
    cv = '0;
    put_lit(0, 0, 0); put_role(0, K_SUM, 0);
    put_lit(1, 1, 0); put_role(1, K_SUM, 1);
    put_lit(2, 3, 0); put_role(2, K_RST, 1);
    put_lit(3, 2, 0); put_role(3, K_SET, 1);
    put_lit(4, 2, 0); put_lit(4, 3, 0); put_role(4, K_CLK, 2);
    put_lit(5, 4, 0); put_role(5, K_SUM, 2);      // feedback of cell 0
    put_lit(6, 5, 1); put_role(6, K_OE, 2);       // inverse feedback of cell 1
    put_mode(0, 6'b100001);
    put_mode(1, 6'b000011);
    put_mode(2, 6'b011001);
    load();

    step(4'b0001, 1'b0, "R7 D capture",          3'b001, 3'b111);
    step(4'b0010, 1'b0, "R7 toggle once",        3'b010, 3'b011);
    step(4'b0010, 1'b0, "R7 toggle back",        3'b000, 3'b111);
    step(4'b0101, 1'b0, "R8 set term",           3'b011, 3'b011);
    step(4'b1101, 1'b0, "R8 R9 R10 reset wins, clock edge", 3'b101, 3'b111);
    step(4'b1100, 1'b0, "R9 no second edge",     3'b100, 3'b111);
    step(4'b0110, 1'b1, "R8 global set/reset first", 3'b001, 3'b111);

    blk_in = '0; g_sr = 1'b0; g_oe = 1'b0;
    #1 check("R11 term enable vs global", 3'b000, 3'b100);
    g_oe = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule